// File: doc/BRIEF.md
# Indirect Extended Register Access Controller

This block lets a small, directly addressed management register space reach a much larger extended register set. Two direct locations carry the whole mechanism. The first is a control register with a 2-bit function field and a 5-bit device field. The second is a window register. Depending on the function field, an access to the window either loads an internal extended-address pointer or goes through to the extended register that the pointer selects. A data access can also post-increment the pointer.

The management side is a plain parallel read/write port with an address, write data, a write enable, a read enable and read data. Read data is combinational within the access cycle. The extended side drives an address, write data and read/write strobes to an external register array and takes its combinational read data back. Serial management framing belongs to the surrounding logic. Software must load the pointer before any extended access returns meaningful data.

Top module: `xreg_indirect`

## Requirements
- R1: After reset the control register reads 0x0000, the pointer is 0, and read data is 0 whenever the read enable is low.
- R2: The control register sits at direct address 0x0D. Bits 15:14 hold the function code and bits 4:0 hold the device field. Bits 13:5 always read 0 and ignore writes.
- R3: With function code 00, a write to the window at direct address 0x0E loads the pointer from the write data, and a read of the window returns the pointer. No extended strobe is raised, whatever the device field holds.
- R4: With function code 01 and device field 0x1F, window reads return the extended register at the pointer and window writes store to it. The pointer does not change.
- R5: With function code 10 and device field 0x1F, the pointer increments by one after every window read and after every window write.
- R6: With function code 11 and device field 0x1F, the pointer increments after window writes only. Window reads leave it unchanged.
- R7: A window read returns the data of the pointer value that holds during that access cycle. Any increment takes effect from the next cycle.
- R8: With a device field other than 0x1F and a function code other than 00, window reads return 0, window writes are ignored, no extended strobe is raised, and the pointer is unchanged.
- R9: A pointer increment from its all-ones value wraps to 0.
- R10: Reads of any direct address other than 0x0D and 0x0E return 0.
- R11: A window access with both enables high in an incrementing function writes the extended register, returns that register's pre-write contents, and advances the pointer exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mgmt_addr | input | 5 | Direct management address |
| mgmt_wdata | input | DW | Management write data |
| mgmt_we | input | 1 | Management write enable |
| mgmt_re | input | 1 | Management read enable |
| mgmt_rdata | output | DW | Management read data, valid in the access cycle |
| ext_addr | output | PW | Extended register address (the pointer) |
| ext_wdata | output | DW | Extended register write data |
| ext_we | output | 1 | Extended register write strobe |
| ext_re | output | 1 | Extended register read strobe |
| ext_rdata | input | DW | Extended register read data, combinational from ext_addr |

## Verification
Two things can fall in the same cycle: a window read that returns extended data, and the pointer step that the same access triggers. A write can also coincide with a read of the same register. The bench provokes the first case with back-to-back reads in post-increment mode. It judges them by whether each cycle returns the register at the pre-step pointer, while the pointer is later read back in load mode. For the second case it drives both enables together. It then expects the old contents on the read data, the new contents on a later read, and a single pointer step.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  typedef enum logic [1:0] {
    FN_LOAD   = 2'b00,
    FN_HOLD   = 2'b01,
    FN_INC_RW = 2'b10,
    FN_INC_WR = 2'b11
  } fn_e;

  typedef struct packed {
    fn_e        fn;
    logic [4:0] dev;
  } ctl_t;

  localparam logic [4:0] CTL_ADDR = 5'h0D;
  localparam logic [4:0] WIN_ADDR = 5'h0E;
  localparam logic [4:0] DEV_EXT  = 5'h1F;
endpackage

// File: rtl/xreg_rst_sync.sv
module xreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xreg_ctl.sv
module xreg_ctl
  import xreg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output ctl_t          ctl_q
);
  ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.fn  = fn_e'(wdata[DW-1 -: 2]);
      ctl_d.dev = wdata[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '{fn: FN_LOAD, dev: 5'h00};
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/xreg_ptr.sv
module xreg_ptr #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          step,
  output logic [PW-1:0] ptr_q
);
  logic [PW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = load | step;
    if (load) ptr_d = load_val;
    else      ptr_d = ptr_q + {{(PW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/xreg_decode.sv
module xreg_decode
  import xreg_pkg::*;
(
  input  logic [4:0] addr,
  input  logic       we,
  input  logic       re,
  input  ctl_t       ctl,
  output logic       ctl_wr,
  output logic       ptr_load,
  output logic       data_ok,
  output logic       x_we,
  output logic       x_re,
  output logic       ptr_step
);
  logic win_hit;

  always_comb begin
    win_hit  = (addr == WIN_ADDR);
    ctl_wr   = we && (addr == CTL_ADDR);
    ptr_load = win_hit && we && (ctl.fn == FN_LOAD);
    data_ok  = (ctl.fn != FN_LOAD) && (ctl.dev == DEV_EXT);
    x_we     = win_hit && we && data_ok;
    x_re     = win_hit && re && data_ok;
    unique case (ctl.fn)
      FN_INC_RW: ptr_step = x_we || x_re;
      FN_INC_WR: ptr_step = x_we;
      default:   ptr_step = 1'b0;
    endcase
  end
endmodule

// File: rtl/xreg_indirect.sv
module xreg_indirect
  import xreg_pkg::*;
#(
  parameter int DW          = 16,
  parameter int PW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    mgmt_addr,
  input  logic [DW-1:0] mgmt_wdata,
  input  logic          mgmt_we,
  input  logic          mgmt_re,
  output logic [DW-1:0] mgmt_rdata,
  output logic [PW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  output logic          ext_we,
  output logic          ext_re,
  input  logic [DW-1:0] ext_rdata
);
  localparam int PAD_W = DW - PW;

  logic       rst_sync_n;
  ctl_t       ctl_q;
  logic       ctl_wr, ptr_load, data_ok, ptr_step;
  logic [PW-1:0] ptr_q;
  logic [1:0] fn_w;
  logic [4:0] dev_w;

  xreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  xreg_ctl #(.DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(ctl_wr),
    .wdata(mgmt_wdata), .ctl_q(ctl_q)
  );

  xreg_decode u_dec (
    .addr(mgmt_addr), .we(mgmt_we), .re(mgmt_re), .ctl(ctl_q),
    .ctl_wr(ctl_wr), .ptr_load(ptr_load), .data_ok(data_ok),
    .x_we(ext_we), .x_re(ext_re), .ptr_step(ptr_step)
  );

  xreg_ptr #(.PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .load(ptr_load),
    .load_val(mgmt_wdata[PW-1:0]), .step(ptr_step), .ptr_q(ptr_q)
  );

  assign ext_addr  = ptr_q;
  assign ext_wdata = mgmt_wdata;
  assign fn_w      = ctl_q.fn;
  assign dev_w     = ctl_q.dev;

  always_comb begin
    mgmt_rdata = '0;
    if (mgmt_re) begin
      if (mgmt_addr == CTL_ADDR) begin
        mgmt_rdata[DW-1 -: 2] = ctl_q.fn;
        mgmt_rdata[4:0]       = ctl_q.dev;
      end else if (mgmt_addr == WIN_ADDR) begin
        if (ctl_q.fn == FN_LOAD) mgmt_rdata = {{PAD_W{1'b0}}, ptr_q};
        else if (data_ok)        mgmt_rdata = ext_rdata;
      end
    end
  end
endmodule

// File: rtl/xreg_chk.sv
module xreg_chk #(
  parameter int DW = 16,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    mgmt_addr,
  input logic          mgmt_re,
  input logic [DW-1:0] mgmt_rdata,
  input logic [PW-1:0] ext_addr,
  input logic          ext_we,
  input logic          ext_re,
  input logic [1:0]    fn,
  input logic [4:0]    dev
);
  AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_re && mgmt_addr == 5'h0D) |-> (mgmt_rdata[DW-3:5] == '0)); // R2
  AST_LOAD_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == 2'b00) |-> (!ext_we && !ext_re)); // R3
  AST_HOLD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == 2'b01 && (ext_we || ext_re)) |=> $stable(ext_addr)); // R4
  AST_STEP_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == 2'b10 && (ext_we || ext_re)) |=> (ext_addr == $past(ext_addr) + 1'b1)); // R5
  AST_RD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == 2'b11 && ext_re && !ext_we) |=> $stable(ext_addr)); // R6
  AST_DEV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev != 5'h1F) |-> (!ext_we && !ext_re)); // R8
endmodule

bind xreg_indirect xreg_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .mgmt_addr(mgmt_addr), .mgmt_re(mgmt_re),
  .mgmt_rdata(mgmt_rdata), .ext_addr(ext_addr), .ext_we(ext_we),
  .ext_re(ext_re), .fn(fn_w), .dev(dev_w)
);

// File: tb/sim_xreg_indirect.sv
`timescale 1ns/1ps
module sim_xreg_indirect;
  localparam int DW = 16;
  localparam int PW = 16;

  logic          clk;
  logic          rst_n;
  logic [4:0]    mgmt_addr;
  logic [DW-1:0] mgmt_wdata;
  logic          mgmt_we, mgmt_re;
  logic [DW-1:0] mgmt_rdata;
  logic [PW-1:0] ext_addr;
  logic [DW-1:0] ext_wdata;
  logic          ext_we, ext_re;
  logic [DW-1:0] ext_rdata;
  logic [DW-1:0] mem [16];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  xreg_indirect #(.DW(DW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .mgmt_we(mgmt_we), .mgmt_re(mgmt_re), .mgmt_rdata(mgmt_rdata),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_we(ext_we),
    .ext_re(ext_re), .ext_rdata(ext_rdata)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // extended register array model, seeded with 0xA000 + index
  assign ext_rdata = mem[ext_addr[3:0]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 16'hA000 + 16'(i);
    end else if (ext_we) begin
      mem[ext_addr[3:0]] <= ext_wdata;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic [4:0] a, input logic [DW-1:0] wd,
                     input logic we, input logic re, output logic [DW-1:0] rd);
    @(negedge clk);
    mgmt_addr = a; mgmt_wdata = wd; mgmt_we = we; mgmt_re = re;
    #1 rd = mgmt_rdata;
    @(posedge clk);
    #0.5;
    mgmt_we = 0; mgmt_re = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [DW-1:0] wd);
    logic [DW-1:0] d;
    acc(a, wd, 1'b1, 1'b0, d);
  endtask

  task automatic rd(input logic [4:0] a, output logic [DW-1:0] d);
    acc(a, '0, 1'b0, 1'b1, d);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    @(negedge clk);
    mgmt_addr = 5'h0D;
    #1 chk("R1 rdata idle", mgmt_rdata, 16'h0000);
    rd(5'h0D, d); chk("R1 control reset", d, 16'h0000);
    rd(5'h0E, d); chk("R1 pointer reset", d, 16'h0000);
  endtask

  task automatic t_ctl();
    logic [DW-1:0] d;
    wr(5'h0D, 16'hFFFF);
    rd(5'h0D, d); chk("R2 reserved bits", d, 16'hC01F);
    wr(5'h0D, 16'h4A35);
    rd(5'h0D, d); chk("R2 field placement", d, 16'h4015);
  endtask

  task automatic t_other();
    logic [DW-1:0] d;
    rd(5'h03, d); chk("R10 addr 0x03", d, 16'h0000);
    rd(5'h1F, d); chk("R10 addr 0x1F", d, 16'h0000);
  endtask

  task automatic t_load();
    logic [DW-1:0] d;
    wr(5'h0D, 16'h0003);           // load mode, device not 0x1F
    wr(5'h0E, 16'h0005);
    rd(5'h0E, d); chk("R3 load ignores device", d, 16'h0005);
    wr(5'h0D, 16'h001F);
    wr(5'h0E, 16'h0005);
    rd(5'h0E, d); chk("R3 pointer readback", d, 16'h0005);
  endtask

  task automatic t_hold();
    logic [DW-1:0] d;
    wr(5'h0D, 16'h401F);
    rd(5'h0E, d); chk("R4 read at pointer", d, 16'hA005);
    wr(5'h0E, 16'h1234);
    rd(5'h0E, d); chk("R4 write same reg", d, 16'h1234);
    wr(5'h0D, 16'h001F);
    rd(5'h0E, d); chk("R4 pointer held", d, 16'h0005);
  endtask

  task automatic t_inc_rw();
    logic [DW-1:0] d;
    wr(5'h0E, 16'h0002);
    wr(5'h0D, 16'h801F);
    rd(5'h0E, d); chk("R7 first read old ptr", d, 16'hA002);
    rd(5'h0E, d); chk("R5 read advances", d, 16'hA003);
    wr(5'h0E, 16'hBEEF);
    wr(5'h0D, 16'h001F);
    rd(5'h0E, d); chk("R5 pointer after r,r,w", d, 16'h0005);
    wr(5'h0E, 16'h0004);
    wr(5'h0D, 16'h401F);
    rd(5'h0E, d); chk("R5 write landed", d, 16'hBEEF);
  endtask

  task automatic t_inc_wr();
    logic [DW-1:0] d;
    wr(5'h0D, 16'h001F);
    wr(5'h0E, 16'h0008);
    wr(5'h0D, 16'hC01F);
    rd(5'h0E, d); chk("R6 read", d, 16'hA008);
    rd(5'h0E, d); chk("R6 read no advance", d, 16'hA008);
    wr(5'h0E, 16'h5555);
    wr(5'h0E, 16'h6666);
    rd(5'h0E, d); chk("R6 writes advance", d, 16'hA00A);
    wr(5'h0D, 16'h001F);
    rd(5'h0E, d); chk("R6 pointer", d, 16'h000A);
    wr(5'h0E, 16'h0009);
    wr(5'h0D, 16'h401F);
    rd(5'h0E, d); chk("R6 second write landed", d, 16'h6666);
  endtask

  task automatic t_dev();
    logic [DW-1:0] d;
    wr(5'h0D, 16'h001F);
    wr(5'h0E, 16'h000A);
    wr(5'h0D, 16'h8005);
    rd(5'h0E, d); chk("R8 read blocked", d, 16'h0000);
    wr(5'h0E, 16'h7777);
    wr(5'h0D, 16'h001F);
    rd(5'h0E, d); chk("R8 pointer unchanged", d, 16'h000A);
    wr(5'h0D, 16'h401F);
    rd(5'h0E, d); chk("R8 write ignored", d, 16'hA00A);
  endtask

  task automatic t_wrap();
    logic [DW-1:0] d;
    wr(5'h0D, 16'h001F);
    wr(5'h0E, 16'hFFFF);
    wr(5'h0D, 16'h801F);
    wr(5'h0E, 16'h0F0F);
    wr(5'h0D, 16'h001F);
    rd(5'h0E, d); chk("R9 wrap to zero", d, 16'h0000);
    wr(5'h0E, 16'h000F);
    wr(5'h0D, 16'h401F);
    rd(5'h0E, d); chk("R9 write at top", d, 16'h0F0F);
  endtask

  task automatic t_same();
    logic [DW-1:0] d;
    wr(5'h0D, 16'h001F);
    wr(5'h0E, 16'h0003);
    wr(5'h0D, 16'h801F);
    acc(5'h0E, 16'hCAFE, 1'b1, 1'b1, d);
    chk("R11 old contents returned", d, 16'hA003);
    wr(5'h0D, 16'h001F);
    rd(5'h0E, d); chk("R11 single step", d, 16'h0004);
    wr(5'h0E, 16'h0003);
    wr(5'h0D, 16'h401F);
    rd(5'h0E, d); chk("R11 write stored", d, 16'hCAFE);
  endtask

  initial begin
    rst_n = 0; mgmt_addr = '0; mgmt_wdata = '0; mgmt_we = 0; mgmt_re = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    t_reset();
    t_ctl();
    t_other();
    t_load();
    t_hold();
    t_inc_rw();
    t_inc_wr();
    t_dev();
    t_wrap();
    t_same();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule